// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block sits beside the address bus of a memory-mapped device and recognises a fixed chain of six read accesses that switches the device's automatic-save feature off or on. No data is written: the command is carried entirely by the order of the read addresses. Five prefix addresses must be read one after another. The sixth address then picks the command: one value disables the feature, a neighbouring value enables it.

A read is counted once per access, on the first clock in which chip enable and output enable are both asserted with write enable low. The detector keeps the current feature setting, which is enabled out of reset. On every completed command it gives a one-cycle done pulse carrying the command code. It also raises a flag meaning the new setting has not yet been saved to nonvolatile storage. The flag stays set until the surrounding save logic reports a finished save.

Top module: `autosave_seq_detector`

## Requirements
- R1: After a synchronous reset, `feature_on` is 1, `unsaved` is 0 and `cmd_done` is 0.
- R2: Reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0B45 clear `feature_on` and give `cmd_done`=1 with `cmd_code`=0. Both appear in the cycle after the clock edge that first samples the sixth read.
- R3: The same five prefix reads followed by a read at 0x0B46 set `feature_on` and give `cmd_done`=1 with `cmd_code`=1, with the same timing as R2.
- R4: A read step is the rising edge of (`ce` and `oe` and not `we`). A read held for several clocks counts as one step. A cycle with only one of `ce` or `oe` asserted is not a step and leaves the sequence untouched.
- R5: A read whose address is not the expected next step returns the detector to idle. If that address is 0x0E38, it counts as the first step of a new sequence.
- R6: Any cycle with `ce` and `we` both asserted aborts a sequence in progress. The detector returns to idle.
- R7: Every completed command sets `unsaved`. A one-cycle `save_done` clears it. If a command completes in the same cycle as `save_done`, `unsaved` ends up set.
- R8: `cmd_done` is high for exactly one cycle per completed command.
- R9: An incomplete or aborted sequence changes neither `feature_on` nor `unsaved`. A sixth read at any address other than the two command addresses has the same lack of effect, and no `cmd_done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| oe | input | 1 | Output enable, active high |
| we | input | 1 | Write enable, active high |
| addr | input | ADDR_W (15) | Access address |
| save_done | input | 1 | One-cycle pulse: the current setting has been saved |
| feature_on | output | 1 | Automatic-save feature enable |
| cmd_done | output | 1 | One-cycle pulse on a completed command |
| cmd_code | output | 1 | Command of the last completion: 1 enable, 0 disable |
| unsaved | output | 1 | Setting changed since the last save |

## Verification
The hardest situation to reach from the ports is a mismatched read that lands on the first prefix address partway through a sequence. It must restart the sequence at step one, not at idle. The stimulus breaks off a partial sequence with 0x0E38 and then completes it from the second step, so a command appears only if the restart was honoured. A second hard case is a command completing in the same cycle as `save_done`. The stimulus drives both on the same clock edge. A third is a strobe held for several cycles, which must still count as a single step.

// File: rtl/asd_pkg.sv
package asd_pkg;
  localparam int PREFIX_LEN = 5;

  function automatic logic [15:0] prefix_addr(input int unsigned i);
    case (i)
      0:       prefix_addr = 16'h0E38;
      1:       prefix_addr = 16'h31C7;
      2:       prefix_addr = 16'h03E0;
      3:       prefix_addr = 16'h3C1F;
      default: prefix_addr = 16'h303F;
    endcase
  endfunction

  localparam logic [15:0] CMD_OFF_ADDR = 16'h0B45;
  localparam logic [15:0] CMD_ON_ADDR  = 16'h0B46;
endpackage

// File: rtl/asd_strobe.sv
module asd_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic oe,
  input  logic we,
  output logic rd_evt,
  output logic wr_act
);
  logic rd_lvl, rd_prev_q;

  assign rd_lvl = ce & oe & ~we;
  assign wr_act = ce & we;
  assign rd_evt = rd_lvl & ~rd_prev_q;

  always_ff @(posedge clk) begin
    if (rst) rd_prev_q <= 1'b0;
    else     rd_prev_q <= rd_lvl;
  end
endmodule

// File: rtl/asd_tracker.sv
module asd_tracker #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  output logic              fire,
  output logic              fire_code,
  output logic              done_q,
  output logic              code_q
);
  localparam int STEPS = asd_pkg::PREFIX_LEN + 1;
  localparam int IDX_W = $clog2(STEPS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [asd_pkg::PREFIX_LEN-1:0] step_hit;
  logic off_hit, on_hit, restart;

  for (genvar g = 0; g < asd_pkg::PREFIX_LEN; g++) begin : g_match
    assign step_hit[g] = (addr == ADDR_W'(asd_pkg::prefix_addr(g)));
  end
  assign off_hit = (addr == ADDR_W'(asd_pkg::CMD_OFF_ADDR));
  assign on_hit  = (addr == ADDR_W'(asd_pkg::CMD_ON_ADDR));
  assign restart = step_hit[0];

  always_comb begin
    fire      = 1'b0;
    fire_code = 1'b0;
    idx_d     = idx_q;
    if (wr_act) begin
      idx_d = '0;
    end else if (rd_evt) begin
      if (idx_q == LAST) begin
        if (off_hit || on_hit) begin
          fire      = 1'b1;
          fire_code = on_hit;
          idx_d     = '0;
        end else begin
          idx_d = restart ? IDX_W'(1) : '0;
        end
      end else if (step_hit[idx_q]) begin
        idx_d = idx_q + IDX_W'(1);
      end else begin
        idx_d = restart ? IDX_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      done_q <= 1'b0;
      code_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      done_q <= fire;
      if (fire) code_q <= fire_code;
    end
  end

  // R6
  wr_abort_chk: assert property (@(posedge clk) disable iff (rst)
    wr_act |=> (idx_q == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);
endmodule

// File: rtl/asd_setting.sv
module asd_setting (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic fire_code,
  input  logic save_done,
  output logic feat_q,
  output logic unsaved_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q    <= 1'b1;
      unsaved_q <= 1'b0;
    end else begin
      if (fire) feat_q <= fire_code;
      if (fire)           unsaved_q <= 1'b1;
      else if (save_done) unsaved_q <= 1'b0;
    end
  end

  // R7
  save_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (save_done && !fire) |=> !unsaved_q);

  // R7
  fire_mark_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> unsaved_q);
endmodule

// File: rtl/autosave_seq_detector.sv
module autosave_seq_detector #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              oe,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              save_done,
  output logic              feature_on,
  output logic              cmd_done,
  output logic              cmd_code,
  output logic              unsaved
);
  logic rd_evt, wr_act, fire, fire_code;

  asd_strobe u_strobe (
    .clk(clk), .rst(rst), .ce(ce), .oe(oe), .we(we),
    .rd_evt(rd_evt), .wr_act(wr_act)
  );

  asd_tracker #(.ADDR_W(ADDR_W)) u_tracker (
    .clk(clk), .rst(rst), .rd_evt(rd_evt), .wr_act(wr_act), .addr(addr),
    .fire(fire), .fire_code(fire_code), .done_q(cmd_done), .code_q(cmd_code)
  );

  asd_setting u_setting (
    .clk(clk), .rst(rst), .fire(fire), .fire_code(fire_code),
    .save_done(save_done), .feat_q(feature_on), .unsaved_q(unsaved)
  );

  // R2 R3
  done_matches_feat_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> (feature_on == cmd_code));

  // R9
  feat_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(feature_on) |-> cmd_done);
endmodule

// File: tb/autosave_seq_detector_tb.sv
module autosave_seq_detector_tb;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, oe = 1'b0, we = 1'b0, save_done = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic feature_on, cmd_done, cmd_code, unsaved;

  int n_chk = 0, n_fail = 0, n_done = 0, n_wide = 0;
  logic last_code = 1'b0, prev_done = 1'b0;

  always #2.5 clk = ~clk;

  autosave_seq_detector #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .oe(oe), .we(we), .addr(addr),
    .save_done(save_done), .feature_on(feature_on), .cmd_done(cmd_done),
    .cmd_code(cmd_code), .unsaved(unsaved)
  );

  always @(negedge clk) begin
    if (cmd_done) begin
      n_done++;
      last_code = cmd_code;
      if (prev_done) n_wide++;
    end
    prev_done = cmd_done;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input int hold);
    ce = 1'b1; oe = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    repeat (hold) @(negedge clk);
    ce = 1'b0; oe = 1'b0;
    @(negedge clk);
  endtask

  task automatic prefix(input int from, input int hold);
    for (int i = from; i < 5; i++) rd(asd_pkg::prefix_addr(i), hold);
  endtask

  task automatic t_reset;
    check(feature_on == 1'b1, "R1", feature_on, 1);
    check(unsaved == 1'b0, "R1", unsaved, 0);
    check(cmd_done == 1'b0, "R1", cmd_done, 0);
  endtask

  task automatic t_disable;
    int d0 = n_done;
    prefix(0, 1);
    rd(16'h0B45, 1);
    check(n_done == d0 + 1, "R2", n_done - d0, 1);
    check(last_code == 1'b0, "R2", last_code, 0);
    check(feature_on == 1'b0, "R2", feature_on, 0);
    check(unsaved == 1'b1, "R7", unsaved, 1);
  endtask

  task automatic t_save;
    save_done = 1'b1; @(negedge clk); save_done = 1'b0;
    check(unsaved == 1'b0, "R7", unsaved, 0);
  endtask

  task automatic t_enable_held;
    int d0 = n_done;
    prefix(0, 3);
    rd(16'h0B46, 4);
    check(n_done == d0 + 1, "R4", n_done - d0, 1);
    check(last_code == 1'b1, "R3", last_code, 1);
    check(feature_on == 1'b1, "R3", feature_on, 1);
    check(n_wide == 0, "R8", n_wide, 0);
  endtask

  task automatic t_half_enable;
    int d0 = n_done;
    rd(asd_pkg::prefix_addr(0), 1);
    rd(asd_pkg::prefix_addr(1), 1);
    ce = 1'b1; oe = 1'b0; addr = ADDR_W'(16'h1234); @(negedge clk);
    ce = 1'b0; oe = 1'b1; @(negedge clk);
    oe = 1'b0;
    prefix(2, 1);
    rd(16'h0B45, 1);
    check(n_done == d0 + 1, "R4", n_done - d0, 1);
    check(feature_on == 1'b0, "R4", feature_on, 0);
  endtask

  task automatic t_restart;
    int d0 = n_done;
    prefix(2, 1);
    rd(asd_pkg::prefix_addr(0), 1);
    rd(asd_pkg::prefix_addr(1), 1);
    rd(asd_pkg::prefix_addr(2), 1);
    rd(asd_pkg::prefix_addr(0), 1);
    prefix(1, 1);
    rd(16'h0B46, 1);
    check(n_done == d0 + 1, "R5", n_done - d0, 1);
    check(feature_on == 1'b1, "R5", feature_on, 1);
  endtask

  task automatic t_mismatch;
    int d0;
    save_done = 1'b1; @(negedge clk); save_done = 1'b0;
    d0 = n_done;
    rd(asd_pkg::prefix_addr(0), 1);
    rd(asd_pkg::prefix_addr(1), 1);
    rd(16'h0000, 1);
    prefix(2, 1);
    rd(16'h0B45, 1);
    check(n_done == d0, "R5", n_done - d0, 0);
    check(feature_on == 1'b1, "R9", feature_on, 1);
    check(unsaved == 1'b0, "R9", unsaved, 0);
  endtask

  task automatic t_write_abort;
    int d0 = n_done;
    rd(asd_pkg::prefix_addr(0), 1);
    rd(asd_pkg::prefix_addr(1), 1);
    rd(asd_pkg::prefix_addr(2), 1);
    ce = 1'b1; we = 1'b1; addr = ADDR_W'(asd_pkg::prefix_addr(3)); @(negedge clk);
    ce = 1'b0; we = 1'b0; @(negedge clk);
    rd(asd_pkg::prefix_addr(3), 1);
    rd(asd_pkg::prefix_addr(4), 1);
    rd(16'h0B45, 1);
    check(n_done == d0, "R6", n_done - d0, 0);
    check(feature_on == 1'b1, "R6", feature_on, 1);
  endtask

  task automatic t_wrong_last;
    int d0 = n_done;
    prefix(0, 1);
    rd(16'h0B47, 1);
    check(n_done == d0, "R9", n_done - d0, 0);
    check(feature_on == 1'b1, "R9", feature_on, 1);
    check(unsaved == 1'b0, "R9", unsaved, 0);
  endtask

  task automatic t_save_collide;
    prefix(0, 1);
    ce = 1'b1; oe = 1'b1; addr = ADDR_W'(16'h0B45); save_done = 1'b1;
    @(negedge clk);
    save_done = 1'b0; ce = 1'b0; oe = 1'b0;
    @(negedge clk);
    check(unsaved == 1'b1, "R7", unsaved, 1);
    check(feature_on == 1'b0, "R2", feature_on, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disable();
    t_save();
    t_enable_held();
    t_half_enable();
    t_restart();
    t_mismatch();
    t_write_abort();
    t_wrong_last();
    t_save_collide();
    check(n_wide == 0, "R8", n_wide, 0);
    finish_run();
  end

  initial begin
    #50000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule